// File: doc/BRIEF.md
# Interrupt Active Priority Tracker

This block records which interrupt priorities are in service on one processor interface. It serves three interrupt groups: Group 0, Group 1 Secure and Group 1 Non-secure. For each group it keeps a bitmap of active priorities. When an interrupt is acknowledged, the block reduces its priority to the group-priority field chosen by that group's grouping setting. It then marks the matching bitmap bit. When an interrupt ends, the block clears the lowest set bit of the ending group's bitmap, which gives up the most urgent priority in service.

From the three bitmaps the block derives two outputs. The running priority is the most urgent priority active in any group. The highest active group is the group that owns that priority. For the first 32 interrupt IDs the block also keeps local pending and active bits. An acknowledge moves such an interrupt from pending to active. An end-of-interrupt deactivates it, unless priority drop and deactivation have been split apart. Choosing the pending interrupt and the shared distributor state lie outside this block.

Top module: `actpri_tracker`

## Requirements
- R1: After reset the running priority is 0xFF, the highest active group reads 3 ("none"), and the local active and pending vectors are all zero.
- R2: Group codes are 0 = Group 0, 1 = Group 1 Secure, 2 = Group 1 Non-secure. An acknowledge with group 0, 1 or 2 computes the mask `0xFF << (g+1)`, where g is that group's grouping value. It masks the priority with it and sets bit `masked >> 1` of that group's 128-bit bitmap. An acknowledge with group code 3 changes nothing.
- R3: The running priority is twice the lowest set bit index over the union of the three bitmaps. It is 0xFF when all three bitmaps are empty.
- R4: The highest active group is the group whose bitmap has the lowest set bit. On a tie, Group 0 wins over Group 1 Secure, and Group 1 Secure wins over Group 1 Non-secure. The output is 3 when no bit is set.
- R5: An accepted end-of-interrupt clears the lowest set bit of its group's bitmap, and no other bitmap bit.
- R6: An end-of-interrupt whose ID is at or above NUM_IRQ (64 by default) is ignored. This includes the special IDs 1020 to 1023.
- R7: An end-of-interrupt is ignored when its group is not the highest active group, or when no group is active.
- R8: With split_mode low, an accepted end-of-interrupt with ID below 32 also clears that ID's active bit. With split_mode high, the active bits are left unchanged.
- R9: A pend_set bit sets the matching pending bit. An acknowledge with ID below 32 sets that ID's active bit and clears its pending bit; the clear wins over a pend_set for the same ID in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grouping_g0 | input | 3 | Priority-grouping value for Group 0 |
| grouping_g1s | input | 3 | Priority-grouping value for Group 1 Secure |
| grouping_g1ns | input | 3 | Priority-grouping value for Group 1 Non-secure |
| split_mode | input | 1 | 1: end-of-interrupt only drops priority |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_group | input | 2 | Group of the acknowledged interrupt |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_id | input | 10 | ID of the acknowledged interrupt |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_group | input | 2 | Group named by the end-of-interrupt |
| eoi_id | input | 10 | ID named by the end-of-interrupt |
| pend_set | input | 32 | Per-ID pending set pulses for local IDs |
| run_prio | output | 8 | Running priority |
| top_group | output | 2 | Highest active group, 3 = none |
| active_local | output | 32 | Active bits of local IDs |
| pending_local | output | 32 | Pending bits of local IDs |

## Verification
The bench targets these corner cases:

- **Ties between groups at the same priority bit.** An arbiter with the wrong tie order would report Group 1 Non-secure or Group 1 Secure instead of Group 0. It would then accept an end-of-interrupt that should be refused.
- **Grouping masks that fold two priorities onto one bit.** A wrong shift would mark a bit one position off, and the running priority would differ by two.
- **End-of-interrupt for special IDs, for the wrong group, or with nothing active.** A design that does not filter these would drop a priority it should keep.
- **Split mode.** A design that ignores it would clear active bits early.

Long random sequences interleave nested acknowledges and drops across all three groups. They check that the lowest-bit clear always removes exactly the most urgent entry.

// File: rtl/actpri_pkg.sv
package actpri_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    localparam int NGRP = 3;

    // group-priority mask for a grouping value: keep bits above position g
    function automatic logic [7:0] prio_mask(input logic [2:0] g);
        return 8'hFF << (int'(g) + 1);
    endfunction

endpackage

// File: rtl/actpri_ffs.sv
module actpri_ffs #(
    parameter int W      = 128,
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    localparam int NW = W / WORD_W;

    logic [NW-1:0] word_nz;

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign word_nz[w] = |vec[w*WORD_W +: WORD_W];
    end

    // first non-zero word, then lowest bit inside it
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (word_nz[w]) begin
                found = 1'b1;
                for (int b = WORD_W - 1; b >= 0; b--) begin
                    if (vec[w*WORD_W + b]) idx = IDX_W'(w*WORD_W + b);
                end
            end
        end
    end

endmodule

// File: rtl/actpri_grp_sel.sv
module actpri_grp_sel
    import actpri_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [NGRP-1:0][IDX_W-1:0] idx,
    input  logic [NGRP-1:0]            found,
    output grp_e                       top
);
    localparam int CW = IDX_W + 1;

    logic [CW-1:0] cnt_g0, cnt_g1s, cnt_g1ns;

    // an empty bitmap counts as one past the last bit
    always_comb begin
        cnt_g0   = found[0] ? CW'(idx[0]) : CW'(1 << IDX_W);
        cnt_g1s  = found[1] ? CW'(idx[1]) : CW'(1 << IDX_W);
        cnt_g1ns = found[2] ? CW'(idx[2]) : CW'(1 << IDX_W);
        if (cnt_g1ns < cnt_g0 && cnt_g1ns < cnt_g1s) top = GRP_G1NS;
        else if (cnt_g1s < cnt_g0)                   top = GRP_G1S;
        else if (found[0])                           top = GRP_G0;
        else                                         top = GRP_NONE;
    end

endmodule

// File: rtl/actpri_tracker.sv
module actpri_tracker
    import actpri_pkg::*;
#(
    parameter int PRIO_W     = 8,
    parameter int APR_BITS   = 128,
    parameter int WORD_W     = 32,
    parameter int ID_W       = 10,
    parameter int NUM_IRQ    = 64,
    parameter int LOCAL_IRQS = 32,
    parameter int BPR_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BPR_W-1:0]      grouping_g0,
    input  logic [BPR_W-1:0]      grouping_g1s,
    input  logic [BPR_W-1:0]      grouping_g1ns,
    input  logic                  split_mode,
    input  logic                  ack_valid,
    input  logic [1:0]            ack_group,
    input  logic [PRIO_W-1:0]     ack_prio,
    input  logic [ID_W-1:0]       ack_id,
    input  logic                  eoi_valid,
    input  logic [1:0]            eoi_group,
    input  logic [ID_W-1:0]       eoi_id,
    input  logic [LOCAL_IRQS-1:0] pend_set,
    output logic [PRIO_W-1:0]     run_prio,
    output logic [1:0]            top_group,
    output logic [LOCAL_IRQS-1:0] active_local,
    output logic [LOCAL_IRQS-1:0] pending_local
);
    localparam int APR_IDX_W = $clog2(APR_BITS);
    localparam int LID_W     = $clog2(LOCAL_IRQS);

    typedef struct packed {
        logic [NGRP-1:0][APR_BITS-1:0] apr;
        logic [LOCAL_IRQS-1:0]         pend;
        logic [LOCAL_IRQS-1:0]         act;
    } state_t;

    state_t st_d, st_q;

    logic [NGRP-1:0][APR_IDX_W-1:0] grp_idx;
    logic [NGRP-1:0]                grp_found;
    logic [APR_IDX_W-1:0]           all_idx;
    logic                           all_found;
    grp_e                           top_d;

    // lowest active bit of each group
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        actpri_ffs #(.W(APR_BITS), .WORD_W(WORD_W), .IDX_W(APR_IDX_W)) u_ffs (
            .vec   (st_q.apr[g]),
            .idx   (grp_idx[g]),
            .found (grp_found[g])
        );
    end

    // lowest active bit over all groups gives the running priority
    actpri_ffs #(.W(APR_BITS), .WORD_W(WORD_W), .IDX_W(APR_IDX_W)) u_ffs_all (
        .vec   (st_q.apr[0] | st_q.apr[1] | st_q.apr[2]),
        .idx   (all_idx),
        .found (all_found)
    );

    actpri_grp_sel #(.IDX_W(APR_IDX_W)) u_sel (
        .idx   (grp_idx),
        .found (grp_found),
        .top   (top_d)
    );

    logic                 ack_ok, eoi_ok;
    logic [BPR_W-1:0]     ack_grouping;
    logic [PRIO_W-1:0]    ack_masked;
    logic [APR_IDX_W-1:0] ack_bit;

    always_comb begin
        st_d = st_q;

        case (ack_group)
            2'd0:    ack_grouping = grouping_g0;
            2'd1:    ack_grouping = grouping_g1s;
            default: ack_grouping = grouping_g1ns;
        endcase
        ack_masked = ack_prio & PRIO_W'({PRIO_W{1'b1}} << (int'(ack_grouping) + 1));
        ack_bit    = APR_IDX_W'(ack_masked >> 1);
        ack_ok     = ack_valid && (ack_group != GRP_NONE);

        eoi_ok = eoi_valid && (eoi_id < ID_W'(NUM_IRQ)) &&
                 (top_d != GRP_NONE) && (eoi_group == top_d);

        // priority drop and optional deactivation
        if (eoi_ok) begin
            st_d.apr[eoi_group][grp_idx[eoi_group]] = 1'b0;
            if (!split_mode && (eoi_id < ID_W'(LOCAL_IRQS)))
                st_d.act[eoi_id[LID_W-1:0]] = 1'b0;
        end

        st_d.pend = st_d.pend | pend_set;

        // acknowledge: mark priority, move local ID from pending to active
        if (ack_ok) begin
            st_d.apr[ack_group][ack_bit] = 1'b1;
            if (ack_id < ID_W'(LOCAL_IRQS)) begin
                st_d.act[ack_id[LID_W-1:0]]  = 1'b1;
                st_d.pend[ack_id[LID_W-1:0]] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_prio      = all_found ? PRIO_W'({all_idx, 1'b0}) : {PRIO_W{1'b1}};
    assign top_group     = top_d;
    assign active_local  = st_q.act;
    assign pending_local = st_q.pend;

endmodule

// File: rtl/actpri_chk.sv
module actpri_chk #(
    parameter int PRIO_W     = 8,
    parameter int ID_W       = 10,
    parameter int NUM_IRQ    = 64,
    parameter int LOCAL_IRQS = 32,
    parameter int BPR_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BPR_W-1:0]      grouping_g0,
    input logic [BPR_W-1:0]      grouping_g1s,
    input logic [BPR_W-1:0]      grouping_g1ns,
    input logic                  split_mode,
    input logic                  ack_valid,
    input logic [1:0]            ack_group,
    input logic [PRIO_W-1:0]     ack_prio,
    input logic [ID_W-1:0]       ack_id,
    input logic                  eoi_valid,
    input logic [1:0]            eoi_group,
    input logic [ID_W-1:0]       eoi_id,
    input logic [LOCAL_IRQS-1:0] pend_set,
    input logic [PRIO_W-1:0]     run_prio,
    input logic [1:0]            top_group,
    input logic [LOCAL_IRQS-1:0] active_local,
    input logic [LOCAL_IRQS-1:0] pending_local
);
    localparam int LID_W = $clog2(LOCAL_IRQS);

    logic [BPR_W-1:0]  sel_grouping;
    logic [PRIO_W-1:0] exp_masked;
    logic              ack_real, ack_loc, eoi_hit;

    always_comb begin
        sel_grouping = (ack_group == 2'd0) ? grouping_g0 :
                       (ack_group == 2'd1) ? grouping_g1s : grouping_g1ns;
        exp_masked = ack_prio & PRIO_W'({PRIO_W{1'b1}} << (int'(sel_grouping) + 1));
        ack_real   = ack_valid && (ack_group != 2'd3);
        ack_loc    = ack_real && (ack_id < ID_W'(LOCAL_IRQS));
        eoi_hit    = eoi_valid && !ack_valid && (eoi_id < ID_W'(NUM_IRQ)) &&
                     (top_group != 2'd3) && (eoi_group == top_group);
    end

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (top_group == 2'd3) |-> (run_prio == {PRIO_W{1'b1}})); // R3

    AST_BUSY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (top_group != 2'd3) |-> (run_prio != {PRIO_W{1'b1}})); // R4

    AST_ACK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_real |=> (run_prio <= $past(exp_masked))); // R2

    AST_ACK_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_loc |=> (active_local[$past(ack_id[LID_W-1:0])] &&
                     !pending_local[$past(ack_id[LID_W-1:0])])); // R9

    AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit |=> (run_prio >= $past(run_prio))); // R5

    AST_EOI_BAD_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && (eoi_id >= ID_W'(NUM_IRQ))) |=>
        ($stable(run_prio) && $stable(top_group) && $stable(active_local))); // R6

    AST_EOI_WRONG_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && (eoi_group != top_group)) |=>
        ($stable(run_prio) && $stable(top_group) && $stable(active_local))); // R7

    AST_SPLIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && split_mode) |=> $stable(active_local)); // R8

endmodule

bind actpri_tracker actpri_chk #(
    .PRIO_W(PRIO_W), .ID_W(ID_W), .NUM_IRQ(NUM_IRQ),
    .LOCAL_IRQS(LOCAL_IRQS), .BPR_W(BPR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .grouping_g0(grouping_g0), .grouping_g1s(grouping_g1s), .grouping_g1ns(grouping_g1ns),
    .split_mode(split_mode),
    .ack_valid(ack_valid), .ack_group(ack_group), .ack_prio(ack_prio), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_group(eoi_group), .eoi_id(eoi_id),
    .pend_set(pend_set),
    .run_prio(run_prio), .top_group(top_group),
    .active_local(active_local), .pending_local(pending_local)
);

// File: tb/sim_actpri_tracker.sv
module sim_actpri_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  grouping_g0 = '0, grouping_g1s = '0, grouping_g1ns = '0;
    logic        split_mode = 1'b0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_group = '0;
    logic [7:0]  ack_prio = '0;
    logic [9:0]  ack_id = '0;
    logic        eoi_valid = 1'b0;
    logic [1:0]  eoi_group = '0;
    logic [9:0]  eoi_id = '0;
    logic [31:0] pend_set = '0;
    logic [7:0]  run_prio;
    logic [1:0]  top_group;
    logic [31:0] active_local, pending_local;

    int checks = 0;
    int errors = 0;

    logic [127:0] m_apr [3];
    logic [31:0]  m_act, m_pend;

    always #4 clk = ~clk;

    actpri_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .grouping_g0(grouping_g0), .grouping_g1s(grouping_g1s), .grouping_g1ns(grouping_g1ns),
        .split_mode(split_mode),
        .ack_valid(ack_valid), .ack_group(ack_group), .ack_prio(ack_prio), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_group(eoi_group), .eoi_id(eoi_id),
        .pend_set(pend_set),
        .run_prio(run_prio), .top_group(top_group),
        .active_local(active_local), .pending_local(pending_local)
    );

    function automatic int f_low(input logic [127:0] v);
        for (int i = 0; i < 128; i++) if (v[i]) return i;
        return 128;
    endfunction

    function automatic int f_top();
        int c0 = f_low(m_apr[0]);
        int c1 = f_low(m_apr[1]);
        int c2 = f_low(m_apr[2]);
        if (c0 == 128 && c1 == 128 && c2 == 128) return 3;
        if (c0 <= c1 && c0 <= c2) return 0;
        if (c1 <= c2) return 1;
        return 2;
    endfunction

    function automatic int f_rprio();
        int c = f_low(m_apr[0] | m_apr[1] | m_apr[2]);
        return (c == 128) ? 255 : 2 * c;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk(run_prio == 8'(f_rprio()), {ctx, " R3 run_prio"}, 32'(run_prio), 32'(f_rprio()));
        chk(top_group == 2'(f_top()), {ctx, " R4 top_group"}, 32'(top_group), 32'(f_top()));
        chk(active_local == m_act, {ctx, " R8 active"}, active_local, m_act);
        chk(pending_local == m_pend, {ctx, " R9 pending"}, pending_local, m_pend);
    endtask

    task automatic do_ack(input logic [1:0] g, input logic [7:0] p, input logic [9:0] id);
        logic [2:0] gp;
        logic [7:0] mk;
        @(negedge clk);
        ack_valid = 1'b1; ack_group = g; ack_prio = p; ack_id = id;
        if (g != 2'd3) begin
            gp = (g == 2'd0) ? grouping_g0 : (g == 2'd1) ? grouping_g1s : grouping_g1ns;
            mk = 8'hFF << (int'(gp) + 1);
            m_apr[g][(p & mk) >> 1] = 1'b1;
            if (id < 10'd32) begin
                m_act[id[4:0]] = 1'b1;
                m_pend[id[4:0]] = 1'b0;
            end
        end
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_eoi(input logic [1:0] g, input logic [9:0] id, input logic sp);
        int t = f_top();
        @(negedge clk);
        eoi_valid = 1'b1; eoi_group = g; eoi_id = id; split_mode = sp;
        if (id < 10'd64 && t != 3 && int'(g) == t) begin
            m_apr[g][f_low(m_apr[g])] = 1'b0;
            if (!sp && id < 10'd32) m_act[id[4:0]] = 1'b0;
        end
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic do_pend(input logic [31:0] v);
        @(negedge clk);
        pend_set = v;
        m_pend = m_pend | v;
        @(negedge clk);
        pend_set = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int g = 0; g < 3; g++) m_apr[g] = '0;
        m_act = '0; m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(run_prio == 8'hFF, "R1 run_prio", 32'(run_prio), 32'hFF);
        chk(top_group == 2'd3, "R1 top_group", 32'(top_group), 32'd3);
        chk(active_local == '0 && pending_local == '0, "R1 local bits",
            active_local | pending_local, 32'd0);

        // R9 pending set, then acknowledge of Group 0 local ID 5
        do_pend(32'h0000_0020);
        check_all("pend");
        do_ack(2'd0, 8'h48, 10'd5);
        chk(run_prio == 8'h48, "R2 ack G0 prio", 32'(run_prio), 32'h48);
        chk(active_local[5] && !pending_local[5], "R9 ack moves ID 5",
            {active_local[5], pending_local[5]}, 32'd2);
        check_all("ack G0");

        // R2 grouping mask: grouping 3 folds 0x2F to 0x20
        grouping_g1ns = 3'd3;
        do_ack(2'd2, 8'h2F, 10'd40);
        chk(run_prio == 8'h20, "R2 grouping mask", 32'(run_prio), 32'h20);
        chk(top_group == 2'd2, "R4 G1NS top", 32'(top_group), 32'd2);

        // R4 tie: Group 1 Secure at the same bit wins over Group 1 Non-secure
        do_ack(2'd1, 8'h20, 10'd6);
        chk(top_group == 2'd1, "R4 tie order", 32'(top_group), 32'd1);

        // R2 group code 3 ignored
        do_ack(2'd3, 8'h00, 10'd7);
        chk(run_prio == 8'h20 && !active_local[7], "R2 group 3 ignored", 32'(run_prio), 32'h20);

        // R7 wrong group ignored
        do_eoi(2'd2, 10'd40, 1'b0);
        chk(top_group == 2'd1, "R7 wrong group", 32'(top_group), 32'd1);
        // R6 special ID ignored
        do_eoi(2'd1, 10'd1021, 1'b0);
        chk(top_group == 2'd1, "R6 special ID", 32'(top_group), 32'd1);
        check_all("ignored eoi");

        // R8 split: drop only
        do_eoi(2'd1, 10'd6, 1'b1);
        chk(active_local[6] == 1'b1, "R8 split keeps active", 32'(active_local[6]), 32'd1);
        chk(top_group == 2'd2 && run_prio == 8'h20, "R5 drop G1S", 32'(top_group), 32'd2);
        do_eoi(2'd2, 10'd40, 1'b0);
        chk(run_prio == 8'h48 && top_group == 2'd0, "R5 drop G1NS", 32'(run_prio), 32'h48);
        do_eoi(2'd0, 10'd5, 1'b0);
        chk(active_local[5] == 1'b0, "R8 non-split clears", 32'(active_local[5]), 32'd0);
        chk(run_prio == 8'hFF, "R3 idle again", 32'(run_prio), 32'hFF);
        // R7 nothing active
        do_eoi(2'd0, 10'd6, 1'b0);
        check_all("R7 idle eoi");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 20);
            if (r < 8) begin
                grouping_g0   = 3'($urandom % 8);
                grouping_g1s  = 3'($urandom % 8);
                grouping_g1ns = 3'($urandom % 8);
                do_ack(2'($urandom % 4), 8'($urandom), 10'($urandom % 70));
            end else if (r < 17) begin
                logic [1:0] g;
                logic [9:0] id;
                g  = ($urandom % 10 < 7 && f_top() != 3) ? 2'(f_top()) : 2'($urandom % 4);
                id = ($urandom % 10 < 8) ? 10'($urandom % 70) : 10'(1020 + $urandom % 4);
                do_eoi(g, id, ($urandom % 3) == 0);
            end else begin
                do_pend($urandom & $urandom);
            end
            check_all("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule